// File: doc/BRIEF.md
# CCD Line-Blanking Clock Sequencer

This block produces the vertical gate waveforms and line control strobes for a four-phase frame-transfer CCD, one line at a time. A pixel-rate clock enable advances an internal pixel position that wraps once per line, and a line counter advances at every wrap. At fixed positions early in each line, the block runs one charge-pump cycle on the four image-gate phases. It interleaves with it one storage-gate transfer cycle, which moves one line into the horizontal output register. Alongside these it drives a stop gate for the horizontal register clocks, a composite blanking strobe, a black-level clamp strobe and a charge-reset (electronic shutter) pulse.

A frame sequencer supplies a two-bit line-kind code for each line, and a shutter request with the number of the line that should carry the charge-reset pulse. Both are sampled at the last pixel position of a line and govern the whole of the next line. Every output is a flop that updates only on an enabled clock edge, so the waveforms are free of glitches and hold their value between pixel enables.

Top module: `lbs_line_seq`

## Requirements
- R1: While reset is asserted and before the first pixel enable, the outputs are idle: `img_ph_o` = 4'b0011 (bit 0 is gate phase 1), `stg_ph_o` = 0, and `reg_stop_o`, `blank_o`, `clamp_o` and `chg_reset_o` are 0.
- R2: All outputs change only on a clock edge with `pix_en` high. On any other edge they hold.
- R3: The pixel position starts at 0 after reset, advances by one per enabled edge and wraps from LINE_LEN-1 to 0. The line counter starts at 0, advances at each wrap and wraps from NUM_LINES-1 to 0. The outputs after an enabled edge reflect the position held before that edge.
- R4: `reg_stop_o` is high for positions 0 to 63 of every line and low otherwise.
- R5: On every line the image phases follow one charge-pump cycle. Phase 1 is low for positions 28..54. Phase 2 stays high. Phase 3 is high for 19..63. Phase 4 is high for 37..45. Outside these windows the phases are at idle.
- R6: On lines of kind 1 (shift), 2 (clamp) or 3 (dump), the storage phases pulse high: phase 1 at 20..49, phase 2 at 26..43, phase 3 at 32..61, phase 4 at 38..55. On kind 0 (hold) they stay low.
- R7: `blank_o` is high at positions below 79 and at positions 1131 and above. On a line of kind 3 (dump) it is high for the whole line.
- R8: `clamp_o` is high for positions 79..98, and only on lines of kind 2 (clamp).
- R9: `chg_reset_o` is high for positions 19..63 (45 pixel periods, 1.25 µs at 36 MHz). This happens only on the line whose line-counter value equals `shutter_line_i`, and only when `shutter_en_i` was high at the end of the preceding line.
- R10: `line_kind_i`, `shutter_en_i` and `shutter_line_i` are sampled only at the enabled edge where the position is LINE_LEN-1. They then govern the following line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate clock enable |
| line_kind_i | input | 2 | Kind of next line: 0 hold, 1 shift, 2 clamp, 3 dump |
| shutter_en_i | input | 1 | Request a charge-reset pulse on the selected line |
| shutter_line_i | input | LINE_W | Line number that receives the charge-reset pulse |
| img_ph_o | output | 4 | Image-gate phases 1..4 |
| stg_ph_o | output | 4 | Storage-gate phases 1..4 |
| reg_stop_o | output | 1 | Stop gate for the horizontal register clocks |
| blank_o | output | 1 | Composite blanking strobe |
| clamp_o | output | 1 | Black-level clamp strobe |
| chg_reset_o | output | 1 | Charge-reset (shutter) pulse |

## Verification
The bench keeps the full line length of 1152 positions, so every edge position is exercised where it really occurs. It builds the block with NUM_LINES = 6, so the line counter wraps several times within about twenty thousand cycles. This makes the shutter match reachable on repeated passes, both with the request enabled and with it disabled. An enable pattern with regular gaps exercises holding between pixel enables. A line-kind schedule visits all four kinds, including changes of kind at consecutive line boundaries.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    LK_HOLD  = 2'd0,
    LK_SHIFT = 2'd1,
    LK_CLAMP = 2'd2,
    LK_DUMP  = 2'd3
  } line_kind_e;

  localparam int NUM_PH      = 4;
  localparam int STOP_END    = 64;
  localparam int CR_START    = 19;
  localparam int CR_LEN      = 45;
  localparam int BLANK_END   = 79;
  localparam int BLANK_START = 1131;
  localparam int CLAMP_START = 79;
  localparam int CLAMP_END   = 99;

  // half-open window test [lo, hi)
  function automatic logic in_span(input int p, input int lo, input int hi);
    return (p >= lo) && (p < hi);
  endfunction

  // image gates: window start per phase
  function automatic int img_lo(input int i);
    case (i)
      0: return 28;
      2: return 19;
      3: return 37;
      default: return 0;
    endcase
  endfunction

  function automatic int img_hi(input int i);
    case (i)
      0: return 55;
      2: return 64;
      3: return 46;
      default: return 0;
    endcase
  endfunction

  // idle level of image phase i (phases 1 and 2 hold the charge)
  function automatic logic img_idle(input int i);
    return (i < 2);
  endfunction

  function automatic int stg_lo(input int i);
    case (i)
      0: return 20;
      1: return 26;
      2: return 32;
      default: return 38;
    endcase
  endfunction

  function automatic int stg_hi(input int i);
    case (i)
      0: return 50;
      1: return 44;
      2: return 62;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/lbs_pos_ctr.sv
module lbs_pos_ctr #(
  parameter int LINE_LEN  = 1152,
  parameter int NUM_LINES = 1250,
  localparam int CNT_W  = $clog2(LINE_LEN),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  output logic [CNT_W-1:0]  pos,
  output logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] next_line,
  output logic              wrap
);

  logic line_last;

  assign wrap      = pix_en && (pos == CNT_W'(LINE_LEN - 1));
  assign line_last = (line == LINE_W'(NUM_LINES - 1));
  assign next_line = line_last ? '0 : line + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= '0;
    end else if (pix_en) begin
      if (wrap) begin
        pos  <= '0;
        line <= next_line;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbs_phase_bank.sv
module lbs_phase_bank
  import lbs_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter bit STORAGE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [CNT_W-1:0]  pos,
  input  logic              active,
  output logic [NUM_PH-1:0] ph
);

  logic [NUM_PH-1:0] idle_vec;
  logic [NUM_PH-1:0] ph_nx;

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    localparam int  LO   = STORAGE ? stg_lo(i) : img_lo(i);
    localparam int  HI   = STORAGE ? stg_hi(i) : img_hi(i);
    localparam logic IDL = STORAGE ? 1'b0 : img_idle(i);
    logic hit;
    assign hit         = active && in_span(int'(pos), LO, HI);
    assign idle_vec[i] = IDL;
    assign ph_nx[i]    = IDL ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= idle_vec;
    else if (pix_en) ph <= ph_nx;
  end

endmodule

// File: rtl/lbs_strobe_gen.sv
module lbs_strobe_gen
  import lbs_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [CNT_W-1:0] pos,
  input  line_kind_e       kind,
  input  logic             shut,
  output logic             reg_stop,
  output logic             blank,
  output logic             clamp,
  output logic             chg_reset
);

  int   p;
  logic stop_nx, blank_nx, clamp_nx, cr_nx;

  assign p        = int'(pos);
  assign stop_nx  = in_span(p, 0, STOP_END);
  assign blank_nx = (kind == LK_DUMP) || (p < BLANK_END) || (p >= BLANK_START);
  assign clamp_nx = (kind == LK_CLAMP) && in_span(p, CLAMP_START, CLAMP_END);
  assign cr_nx    = shut && in_span(p, CR_START, CR_START + CR_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_stop  <= 1'b0;
      blank     <= 1'b0;
      clamp     <= 1'b0;
      chg_reset <= 1'b0;
    end else if (pix_en) begin
      reg_stop  <= stop_nx;
      blank     <= blank_nx;
      clamp     <= clamp_nx;
      chg_reset <= cr_nx;
    end
  end

endmodule

// File: rtl/lbs_line_seq.sv
module lbs_line_seq
  import lbs_pkg::*;
#(
  parameter int LINE_LEN  = 1152,
  parameter int NUM_LINES = 1250,
  localparam int CNT_W  = $clog2(LINE_LEN),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [1:0]        line_kind_i,
  input  logic              shutter_en_i,
  input  logic [LINE_W-1:0] shutter_line_i,
  output logic [3:0]        img_ph_o,
  output logic [3:0]        stg_ph_o,
  output logic              reg_stop_o,
  output logic              blank_o,
  output logic              clamp_o,
  output logic              chg_reset_o
);

  logic [CNT_W-1:0]  pos;
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] next_line;
  logic              wrap;
  line_kind_e        kind_q;
  logic              shut_q;
  logic              shut_hit;
  logic              stg_active;

  lbs_pos_ctr #(.LINE_LEN(LINE_LEN), .NUM_LINES(NUM_LINES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .pos(pos), .line(line), .next_line(next_line), .wrap(wrap)
  );

  // next-line controls are captured at the last position (R10)
  assign shut_hit = shutter_en_i && (next_line == shutter_line_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= LK_HOLD;
      shut_q <= 1'b0;
    end else if (wrap) begin
      kind_q <= line_kind_e'(line_kind_i);
      shut_q <= shut_hit;
    end
  end

  assign stg_active = (kind_q != LK_HOLD);

  lbs_phase_bank #(.CNT_W(CNT_W), .STORAGE(1'b0)) u_img (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pos(pos),
    .active(1'b1), .ph(img_ph_o)
  );

  lbs_phase_bank #(.CNT_W(CNT_W), .STORAGE(1'b1)) u_stg (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pos(pos),
    .active(stg_active), .ph(stg_ph_o)
  );

  lbs_strobe_gen #(.CNT_W(CNT_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pos(pos),
    .kind(kind_q), .shut(shut_q),
    .reg_stop(reg_stop_o), .blank(blank_o), .clamp(clamp_o),
    .chg_reset(chg_reset_o)
  );

endmodule

// File: rtl/lbs_line_seq_chk.sv
module lbs_line_seq_chk
  import lbs_pkg::*;
#(
  parameter int LINE_LEN = 1152,
  parameter int CNT_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [CNT_W-1:0] pos,
  input line_kind_e       kind_q,
  input logic             shut_q,
  input logic [3:0]       img_ph_o,
  input logic [3:0]       stg_ph_o,
  input logic             reg_stop_o,
  input logic             blank_o,
  input logic             clamp_o,
  input logic             chg_reset_o
);

  // R2
  hold_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({img_ph_o, stg_ph_o, reg_stop_o, blank_o, clamp_o, chg_reset_o}));

  // R3
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < LINE_LEN);

  // R4
  storage_under_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_ph_o != 4'b0) |-> reg_stop_o);

  // R5
  charge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(img_ph_o) >= 2);

  // R6
  hold_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == LK_HOLD) |-> (stg_ph_o == 4'b0));

  // R8
  clamp_on_clamp_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> (!reg_stop_o && kind_q == LK_CLAMP));

  // R9
  reset_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_reset_o |-> shut_q);

  // R9
  reset_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_reset_o) |-> reg_stop_o);

endmodule

bind lbs_line_seq lbs_line_seq_chk #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pos(pos), .kind_q(kind_q),
  .shut_q(shut_q), .img_ph_o(img_ph_o), .stg_ph_o(stg_ph_o),
  .reg_stop_o(reg_stop_o), .blank_o(blank_o), .clamp_o(clamp_o),
  .chg_reset_o(chg_reset_o)
);

// File: tb/test_lbs_line_seq.sv
module test_lbs_line_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LL         = 1152;
  localparam int NL         = 6;
  localparam int LW         = $clog2(NL);
  localparam int SHUT_LINE  = 2;
  localparam int RUN_LINES  = 16;
  localparam int WD_LIMIT   = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_en;
  logic [1:0]    line_kind_i;
  logic          shutter_en_i;
  logic [LW-1:0] shutter_line_i;
  logic [3:0]    img_ph_o, stg_ph_o;
  logic          reg_stop_o, blank_o, clamp_o, chg_reset_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lbs_line_seq #(.LINE_LEN(LL), .NUM_LINES(NL)) i_lbs_line_seq (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_kind_i(line_kind_i),
    .shutter_en_i(shutter_en_i), .shutter_line_i(shutter_line_i),
    .img_ph_o(img_ph_o), .stg_ph_o(stg_ph_o), .reg_stop_o(reg_stop_o),
    .blank_o(blank_o), .clamp_o(clamp_o), .chg_reset_o(chg_reset_o)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference waveforms, written from the requirements
  function automatic int m_img(input int p);
    int v = 0;
    if (!(p >= 28 && p <= 54)) v += 1;
    v += 2;
    if (p >= 19 && p <= 63) v += 4;
    if (p >= 37 && p <= 45) v += 8;
    return v;
  endfunction

  function automatic int m_stg(input int p, input int k);
    int v = 0;
    if (k == 0) return 0;
    if (p >= 20 && p <= 49) v += 1;
    if (p >= 26 && p <= 43) v += 2;
    if (p >= 32 && p <= 61) v += 4;
    if (p >= 38 && p <= 55) v += 8;
    return v;
  endfunction

  function automatic int kind_for(input int idx);
    return (idx * 3 + 1) % 4;
  endfunction

  function automatic bit shut_for(input int idx);
    return idx != 8;
  endfunction

  int e_img = 3, e_stg = 0, e_stop = 0, e_blank = 0, e_clamp = 0, e_cr = 0;

  task automatic check_all(input string tag);
    chk(tag == "" ? "R5" : tag, "img_ph", int'(img_ph_o), e_img);
    chk(tag == "" ? "R6" : tag, "stg_ph", int'(stg_ph_o), e_stg);
    chk(tag == "" ? "R4" : tag, "reg_stop", int'(reg_stop_o), e_stop);
    chk(tag == "" ? "R7" : tag, "blank", int'(blank_o), e_blank);
    chk(tag == "" ? "R8" : tag, "clamp", int'(clamp_o), e_clamp);
    chk(tag == "" ? "R9" : tag, "chg_reset", int'(chg_reset_o), e_cr);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p = 0, ln = 0, idx = 0, k_cur = 0, cyc = 0;
    bit s_cur = 0;
    rst_n          = 1'b0;
    pix_en         = 1'b0;
    line_kind_i    = 2'd0;
    shutter_en_i   = 1'b0;
    shutter_line_i = LW'(SHUT_LINE);
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    while (idx < RUN_LINES) begin
      bit en = (cyc % 7) != 3;
      pix_en       = en;
      line_kind_i  = 2'(kind_for(idx + 1));
      shutter_en_i = shut_for(idx + 1);
      @(negedge clk);
      if (en) begin
        e_img   = m_img(p);
        e_stg   = m_stg(p, k_cur);
        e_stop  = (p < 64) ? 1 : 0;
        e_blank = (k_cur == 3 || p < 79 || p >= 1131) ? 1 : 0;
        e_clamp = (k_cur == 2 && p >= 79 && p <= 98) ? 1 : 0;
        e_cr    = (s_cur && p >= 19 && p <= 63) ? 1 : 0;
        check_all("");
        if (p == 0 && idx > 0) chk("R3", "reg_stop at line start", int'(reg_stop_o), 1);
        if (p == LL - 1) begin
          p = 0;
          idx++;
          ln = (ln + 1) % NL;
          // R10: values presented at the last position govern the new line
          k_cur = kind_for(idx);
          s_cur = shut_for(idx) && (ln == SHUT_LINE);
        end else begin
          p++;
        end
      end else begin
        check_all("R2");
      end
      cyc++;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule